// File: doc/BRIEF.md
# Positional Register SPI Slave

This block is an SPI slave that exposes a bank of eight byte-wide peripheral registers without any address or command byte. Inside a chip-select-framed message, the position of a byte is its register index. The first byte goes to register 0, the next byte goes to register 1, and so on. While a byte arrives, the current value of the register at that position is shifted back out, so each transfer is a full-duplex exchange of one register array.

The serial side runs only on the master's bit clock and never starts traffic by itself. Each completed write crosses into the peripheral's own clock through a toggle handshake. There it appears as a one-cycle strobe with an index and a data value, and it updates a bank that the peripheral reads in parallel. The two top positions carry status bytes that the peripheral drives. The master can read them but cannot write them.

Top module: `spi_posreg_slave`

## Requirements
- R1: Mode 0 timing applies. MOSI is sampled on the rising SCLK edge and MISO changes only after a falling edge. Both directions move one bit per SCLK cycle, most significant bit first.
- R2: Lowering `cs_n` restarts the byte position at 0 and the bit position at the MSB. Bit 7 of register 0 is on `miso` before the first SCLK edge of every message.
- R3: A complete byte at position n, with n from 0 to 5, produces exactly one `wr_stb` pulse of one `clk` cycle, with `wr_idx` = n and `wr_data` = the byte. Register n in `regs_o` (bits n*8+7..n*8) takes the byte on the same edge and holds it at all other times.
- R4: During byte n, `miso` carries the current value of register n. Registers 0 to 5 come from `regs_o`, register 6 from `status_i[7:0]` and register 7 from `status_i[15:8]`.
- R5: Bytes at positions 6 and 7 cause no strobe and change no register.
- R6: Bytes at position 8 and above are discarded, and `miso` returns 0x00 for them.
- R7: If `cs_n` rises after only part of a byte, that byte is dropped: no strobe and no register change.
- R8: `miso` is 0 whenever `cs_n` is high.
- R9: `wr_stb` is raised within 2 to 5 `clk` cycles after the rising SCLK edge that completes the byte.
- R10: While `rst_n` is low, `regs_o` is all zero, `wr_stb` is low and `miso` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral system clock |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| sclk | input | 1 | SPI bit clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select that frames a message |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 while deselected |
| status_i | input | 16 | Read-only bytes for positions 6 (low) and 7 (high) |
| regs_o | output | 48 | Writable registers 0..5, register n at bits n*8+7..n*8 |
| wr_stb | output | 1 | One-cycle pulse per committed write |
| wr_idx | output | 3 | Register index of the committed write |
| wr_data | output | 8 | Data of the committed write |

## Verification
Serial results appear within a half SCLK period. The bench samples `miso` 20 ns after each falling edge. It samples again 10 ns after the following rising edge, to confirm that the bit did not move on the rising edge. Every completed writable byte is queued at its eighth rising edge, together with the `clk` cycle count. On each falling `clk` edge, the reference compares the strobe, index and data with the head of that queue. It requires the strobe to arrive no more than 5 cycles after the byte completed, compares the whole register bank with its model, and reports any queued write that has not arrived after 6 cycles.

// File: rtl/spi_posreg_slave.sv
`timescale 1ns/1ps
module spi_posreg_slave #(
  parameter int NREG = 8,
  parameter int NRW  = 6,
  parameter int W    = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [(NREG-NRW)*W-1:0] status_i,
  output logic [NRW*W-1:0]      regs_o,
  output logic                  wr_stb,
  output logic [IW-1:0]         wr_idx,
  output logic [W-1:0]          wr_data
);
  localparam int BW = $clog2(W);
  localparam int CW = IW + 1;

  logic          spi_clr;
  logic [BW-1:0] bit_cnt;
  logic [CW-1:0] byte_cnt;
  logic [W-2:0]  rx_sh;
  logic [W-1:0]  rx_byte;
  logic          last_bit, in_range, wr_pos;
  logic          hold_tgl;
  logic [IW-1:0] hold_idx;
  logic [W-1:0]  hold_data;
  logic          started, miso_q, cur_bit;
  logic [2:0]    sync;
  logic          pulse;
  logic [W-1:0]  bank [NRW];
  logic [W-1:0]  view [NREG];

  assign spi_clr  = cs_n | ~rst_n;
  assign rx_byte  = {rx_sh, mosi};
  assign last_bit = (bit_cnt == BW'(W-1));
  assign in_range = (byte_cnt < CW'(NREG));
  assign wr_pos   = (byte_cnt < CW'(NRW));

  // serial receive side, cleared whenever the slave is deselected
  always_ff @(posedge sclk or posedge spi_clr) begin
    if (spi_clr) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
    end else begin
      rx_sh   <= rx_byte[W-2:0];
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      if (last_bit && in_range) byte_cnt <= byte_cnt + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_tgl  <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
    end else if (!cs_n && last_bit && wr_pos) begin
      hold_tgl  <= ~hold_tgl;
      hold_idx  <= byte_cnt[IW-1:0];
      hold_data <= rx_byte;
    end
  end

  // read view: writable bank below, peripheral status above
  for (genvar g = 0; g < NREG; g++) begin : g_view
    if (g < NRW) begin : g_rw
      assign view[g] = bank[g];
    end else begin : g_ro
      assign view[g] = status_i[(g-NRW)*W +: W];
    end
  end

  always_comb begin
    cur_bit = 1'b0;
    if (in_range) cur_bit = view[byte_cnt[IW-1:0]][BW'(W-1) - bit_cnt];
  end

  always_ff @(negedge sclk or posedge spi_clr) begin
    if (spi_clr) begin
      started <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      started <= 1'b1;
      miso_q  <= cur_bit;
    end
  end

  assign miso = cs_n ? 1'b0 : (started ? miso_q : view[0][W-1]);

  // system clock side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], hold_tgl};
  end

  assign pulse = sync[2] ^ sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      for (int i = 0; i < NRW; i++) bank[i] <= '0;
    end else begin
      wr_stb <= pulse;
      if (pulse) begin
        wr_idx  <= hold_idx;
        wr_data <= hold_data;
        if (int'(hold_idx) < NRW) bank[hold_idx] <= hold_data;
      end
    end
  end

  for (genvar g = 0; g < NRW; g++) begin : g_out
    assign regs_o[g*W +: W] = bank[g];
  end
endmodule

// File: rtl/spi_posreg_chk.sv
`timescale 1ns/1ps
module spi_posreg_chk #(
  parameter int NREG = 8,
  parameter int NRW  = 6,
  parameter int W    = 8,
  parameter int IW   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               miso,
  input logic               wr_stb,
  input logic [IW-1:0]      wr_idx,
  input logic [W-1:0]       wr_data,
  input logic [NRW*W-1:0]   regs_o
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r5_rw_index_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_idx) < NRW));
  a_r3_bank_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wr_idx) < NRW) |-> (regs_o[int'(wr_idx)*W +: W] == wr_data));
  a_r3_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(regs_o));
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
endmodule

bind spi_posreg_slave spi_posreg_chk #(.NREG(NREG), .NRW(NRW), .W(W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .wr_stb(wr_stb),
  .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(regs_o)
);

// File: tb/sim_spi_posreg_slave.sv
`timescale 1ns/1ps
module sim_spi_posreg_slave;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_stb;
  logic [15:0] status = 16'h0;
  logic [47:0] regs_o;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_data;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 0;
  int mbank [6];
  int q_idx[$], q_dat[$], q_cyc[$];
  logic [7:0] txb [16];

  spi_posreg_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .status_i(status), .regs_o(regs_o), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int b);
    if (b < 6) return mbank[b];
    if (b < 8) return int'(status[(b-6)*8 +: 8]);
    return 0;
  endfunction

  function automatic logic [47:0] model_vec();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = mbank[i][7:0];
    return v;
  endfunction

  // reference: write queue against strobes, bank compare every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_stb) begin
        if (q_idx.size() == 0) chk(1'b0, "R3 R5 R7 unexpected strobe", wr_idx, 0);
        else begin
          chk(wr_idx == q_idx[0][2:0], "R3 index", wr_idx, q_idx[0]);
          chk(wr_data == q_dat[0][7:0], "R3 data", wr_data, q_dat[0]);
          chk(cyc - q_cyc[0] <= 5, "R9 latency", cyc - q_cyc[0], 5);
          mbank[q_idx[0]] = q_dat[0];
          void'(q_idx.pop_front()); void'(q_dat.pop_front()); void'(q_cyc.pop_front());
        end
      end
      if (q_cyc.size() > 0 && cyc - q_cyc[0] > 6) begin
        chk(1'b0, "R9 missing strobe", q_idx[0], q_dat[0]);
        void'(q_idx.pop_front()); void'(q_dat.pop_front()); void'(q_cyc.pop_front());
      end
      chk(regs_o == model_vec(), "R3 bank", regs_o, model_vec());
      if (cs_n) chk(!miso, "R8 idle miso", miso, 0);
    end
  end

  task automatic msg(input int n, input int tail);
    cs_n = 1'b0;
    #20;
    for (int b = 0; b < n + (tail > 0 ? 1 : 0); b++) begin
      int nb = (b < n) ? 8 : tail;
      int e = exp_rd(b);
      for (int k = 7; k >= 8 - nb; k--) begin
        mosi = txb[b][k];
        #20;
        chk(miso == e[k], (b >= 8) ? "R6 beyond" : ((b == 0 && k == 7) ? "R2 first bit" : "R1 R4 miso"), miso, e[k]);
        #20;
        sclk = 1'b1;
        if (k == 0 && b < 6) begin
          q_idx.push_back(b); q_dat.push_back(int'(txb[b])); q_cyc.push_back(cyc);
        end
        #10;
        chk(miso == e[k], "R1 stable over rise", miso, e[k]);
        #30;
        sclk = 1'b0;
      end
    end
    #20;
    cs_n = 1'b1;
    #10;
    chk(!miso, "R8 after deselect", miso, 0);
    repeat (20) @(posedge clk);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mbank[i] = 0;
    repeat (3) @(negedge clk);
    chk(regs_o == 48'h0, "R10 regs", regs_o, 0);
    chk(!wr_stb, "R10 strobe", wr_stb, 0);
    chk(!miso, "R10 miso", miso, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // plain write of all writable positions, readback zeros
    txb[0] = 8'hA5; txb[1] = 8'h3C; txb[2] = 8'hFF; txb[3] = 8'h00; txb[4] = 8'h81; txb[5] = 8'h7E;
    msg(6, 0);

    // full array: read back, status positions, writes to 6/7 ignored (R5)
    status = 16'hBEEF;
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'h44; txb[4] = 8'h55; txb[5] = 8'h66;
    txb[6] = 8'h77; txb[7] = 8'h88;
    msg(8, 0);

    // overlong message (R6), new status
    status = 16'h5AC3;
    for (int i = 0; i < 10; i++) txb[i] = 8'(8'hF0 ^ (i * 8'h13));
    msg(10, 0);

    // partial trailing byte is dropped (R7)
    txb[0] = 8'h01; txb[1] = 8'h02; txb[2] = 8'hEE;
    msg(2, 5);

    // register 2 must still hold its earlier value (R7 at ports)
    txb[0] = 8'hC0; txb[1] = 8'hDE; txb[2] = 8'h99;
    msg(3, 0);

    repeat (40) @(posedge clk);
    chk(q_idx.size() == 0, "R9 pending writes", q_idx.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule